// File: doc/BRIEF.md
# Serial Binary Magnitude Comparator

This block compares two unsigned binary numbers X and Y that arrive one bit pair per clock, most significant bit first. A two-bit relation register records whether the bits seen so far make X equal to, greater than or less than Y. Three one-hot outputs decode that register continuously, so the comparison result is available one clock after the last bit pair of a word.

The update of the relation register is one cell of a unilateral iterative comparator. Each cell looks only at its incoming relation and its own bit pair. The same cell module is also unrolled into a combinational array that is WIDTH cells long. The array compares two parallel words and serves as a cross-check of the serial path.

A synchronous `start` begins a new word. If `valid` is high on the same clock, that bit pair becomes the first pair of the new word. Bit pairs with `valid` low leave the relation unchanged.

Top module: `mag_compare`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the relation is cleared to equal. After that edge `out_eq` is 1 and `out_lt` and `out_gt` are 0.
- R2: `start` high with `valid` low clears the relation to equal at that clock edge, whatever the relation was before.
- R3: `start` high with `valid` high first clears the relation and then applies the presented pair. After the edge the relation is greater if xi=1 and yi=0, less if xi=0 and yi=1, and equal otherwise.
- R4: `valid` low with `start` low leaves the relation unchanged. The values on `xi` and `yi` have no effect.
- R5: While the relation is equal, a valid pair with xi=1 and yi=0 moves it to greater, xi=0 with yi=1 moves it to less, and equal bits keep it equal.
- R6: Once the relation is greater or less, further valid pairs with `start` low do not change it.
- R7: Exactly one of `out_lt`, `out_eq`, `out_gt` is 1 at all times. The relation is held in two bits: 00 is equal, 10 is greater and 01 is less. Code 11 is never stored, and a cell reads it as equal.
- R8: After WIDTH valid pairs of a word, sent most significant bit first and starting with a `start`, the serial outputs show X<Y on `out_lt`, X==Y on `out_eq` and X>Y on `out_gt`. Clocks with `valid` low may be inserted between the pairs.
- R9: The array outputs `arr_lt`, `arr_eq`, `arr_gt` combinationally give the unsigned comparison of `arr_x` with `arr_y`, with exactly one of them high.
- R10: For the same X and Y, the array outputs equal the serial outputs after the word has been sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new word, clearing the relation to equal |
| valid | input | 1 | xi and yi carry a bit pair this clock |
| xi | input | 1 | Current bit of X, most significant first |
| yi | input | 1 | Current bit of Y, most significant first |
| out_lt | output | 1 | Serial result: X less than Y |
| out_eq | output | 1 | Serial result: X equal to Y |
| out_gt | output | 1 | Serial result: X greater than Y |
| arr_x | input | WIDTH | Parallel X for the array form |
| arr_y | input | WIDTH | Parallel Y for the array form |
| arr_lt | output | 1 | Array result: arr_x less than arr_y |
| arr_eq | output | 1 | Array result: arr_x equal to arr_y |
| arr_gt | output | 1 | Array result: arr_x greater than arr_y |

## Verification
The bench builds the block with WIDTH=4, so all 256 pairs of operands fit in an exhaustive sweep. That sweep drives the serial path and the four-cell array with the same operands and checks both against each other. A small table of hand-picked words covers the extremes, such as all-ones against all-zeros and operands that differ only in the least significant bit. Directed sequences then cover the cases that need a particular timing:
- `start` arriving while the relation is already greater or less;
- `start` coinciding with `valid`;
- bubbles with `valid` low carrying misleading bits;
- a reset in the middle of a word.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

    // Relation of X to Y over the bits seen so far (fixed two-bit code)
    typedef enum logic [1:0] {
        REL_EQ = 2'b00,
        REL_LT = 2'b01,
        REL_GT = 2'b10,
        REL_XX = 2'b11
    } rel_e;

    typedef struct packed {
        rel_e rel;
    } core_s;

endpackage

// File: rtl/mag_cell.sv
module mag_cell
    import magcmp_pkg::*;
(
    input  rel_e rel_in,
    input  logic x_bit,
    input  logic y_bit,
    output rel_e rel_out
);

    always_comb begin
        rel_out = rel_in;
        if (rel_in == REL_EQ || rel_in == REL_XX) begin
            if (x_bit && !y_bit) begin
                rel_out = REL_GT;
            end else if (!x_bit && y_bit) begin
                rel_out = REL_LT;
            end else begin
                rel_out = REL_EQ;
            end
        end
    end

endmodule

// File: rtl/mag_decode.sv
module mag_decode
    import magcmp_pkg::*;
(
    input  rel_e rel,
    output logic is_lt,
    output logic is_eq,
    output logic is_gt
);

    always_comb begin
        is_lt = 1'b0;
        is_eq = 1'b0;
        is_gt = 1'b0;
        unique case (rel)
            REL_LT:  is_lt = 1'b1;
            REL_GT:  is_gt = 1'b1;
            default: is_eq = 1'b1;
        endcase
    end

endmodule

// File: rtl/mag_array.sv
module mag_array
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_word,
    input  logic [WIDTH-1:0] b_word,
    output rel_e             rel_final
);

    localparam int NLINK = WIDTH + 1;

    rel_e link [NLINK];

    assign link[WIDTH] = REL_EQ;

    for (genvar g = WIDTH - 1; g >= 0; g--) begin : g_cell
        mag_cell i_cell (
            .rel_in (link[g+1]),
            .x_bit  (a_word[g]),
            .y_bit  (b_word[g]),
            .rel_out(link[g])
        );
    end

    assign rel_final = link[0];

endmodule

// File: rtl/mag_serial.sv
module mag_serial
    import magcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic valid,
    input  logic xi,
    input  logic yi,
    output rel_e rel
);

    core_s st_d, st_q;
    rel_e  cell_in, cell_out;

    assign cell_in = start ? REL_EQ : st_q.rel;

    mag_cell i_step (
        .rel_in (cell_in),
        .x_bit  (xi),
        .y_bit  (yi),
        .rel_out(cell_out)
    );

    always_comb begin
        st_d = st_q;
        if (valid) begin
            st_d.rel = cell_out;
        end else if (start) begin
            st_d.rel = REL_EQ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rel: REL_EQ};
        end else begin
            st_q <= st_d;
        end
    end

    assign rel = st_q.rel;

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !valid) |=> (st_q.rel == REL_EQ));

    // R4
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !valid) |=> $stable(st_q.rel));

    // R6
    gt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && st_q.rel == REL_GT) |=> (st_q.rel == REL_GT));

    // R6
    lt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && st_q.rel == REL_LT) |=> (st_q.rel == REL_LT));

    // R7
    no_unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rel != REL_XX);

endmodule

// File: rtl/mag_compare.sv
module mag_compare
    import magcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             valid,
    input  logic             xi,
    input  logic             yi,
    output logic             out_lt,
    output logic             out_eq,
    output logic             out_gt,
    input  logic [WIDTH-1:0] arr_x,
    input  logic [WIDTH-1:0] arr_y,
    output logic             arr_lt,
    output logic             arr_eq,
    output logic             arr_gt
);

    rel_e ser_rel, arr_rel;

    mag_serial i_serial (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .valid(valid),
        .xi   (xi),
        .yi   (yi),
        .rel  (ser_rel)
    );

    mag_decode i_ser_dec (
        .rel  (ser_rel),
        .is_lt(out_lt),
        .is_eq(out_eq),
        .is_gt(out_gt)
    );

    mag_array #(.WIDTH(WIDTH)) i_array (
        .a_word   (arr_x),
        .b_word   (arr_y),
        .rel_final(arr_rel)
    );

    mag_decode i_arr_dec (
        .rel  (arr_rel),
        .is_lt(arr_lt),
        .is_eq(arr_eq),
        .is_gt(arr_gt)
    );

    // R7
    ser_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({out_lt, out_eq, out_gt}));

    // R9
    arr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_gt == (arr_x > arr_y)) && (arr_lt == (arr_x < arr_y)));

    // R9
    arr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({arr_lt, arr_eq, arr_gt}) == 1);

endmodule

// File: tb/test_mag_compare.sv
`timescale 1ns/1ps
module test_mag_compare;

    localparam int W = 4;

    // table entry: {x, y, expected code}; code 0 = equal, 1 = less, 2 = greater
    localparam int NVEC = 8;
    localparam logic [2*W+1:0] VEC [NVEC] = '{
        {4'hF, 4'h0, 2'd2},
        {4'h0, 4'hF, 2'd1},
        {4'h0, 4'h0, 2'd0},
        {4'hF, 4'hF, 2'd0},
        {4'h8, 4'h7, 2'd2},
        {4'h6, 4'h7, 2'd1},
        {4'hA, 4'hA, 2'd0},
        {4'h5, 4'h4, 2'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, valid = 1'b0, xi = 1'b0, yi = 1'b0;
    logic [W-1:0] arr_x = '0, arr_y = '0;
    logic out_lt, out_eq, out_gt, arr_lt, arr_eq, arr_gt;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mag_compare #(.WIDTH(W)) i_mag_compare (
        .clk(clk), .rst_n(rst_n), .start(start), .valid(valid),
        .xi(xi), .yi(yi),
        .out_lt(out_lt), .out_eq(out_eq), .out_gt(out_gt),
        .arr_x(arr_x), .arr_y(arr_y),
        .arr_lt(arr_lt), .arr_eq(arr_eq), .arr_gt(arr_gt)
    );

    function automatic logic [2:0] code_vec(input logic [1:0] c);
        case (c)
            2'd1:    return 3'b001;
            2'd2:    return 3'b100;
            default: return 3'b010;
        endcase
    endfunction

    function automatic logic [2:0] ref_vec(input logic [W-1:0] a, input logic [W-1:0] b);
        if (a > b) return 3'b100;
        if (a < b) return 3'b001;
        return 3'b010;
    endfunction

    task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got {gt,eq,lt}=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // drive at a falling edge, then wait to the next falling edge
    task automatic step(input logic s, input logic v, input logic x, input logic y);
        start = s; valid = v; xi = x; yi = y;
        @(negedge clk);
    endtask

    task automatic send_word(input logic [W-1:0] a, input logic [W-1:0] b, input bit gaps);
        for (int i = W - 1; i >= 0; i--) begin
            step(i == W - 1, 1'b1, a[i], b[i]);
            if (gaps) step(1'b0, 1'b0, ~a[i], b[i]);
        end
        start = 1'b0; valid = 1'b0;
    endtask

    function automatic logic [2:0] ser_out();
        return {out_gt, out_eq, out_lt};
    endfunction

    function automatic logic [2:0] arr_out();
        return {arr_gt, arr_eq, arr_lt};
    endfunction

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset", ser_out(), 3'b010);
        rst_n = 1'b1;

        // table walk: serial, array and agreement
        for (int k = 0; k < NVEC; k++) begin
            logic [W-1:0] a, b;
            a = VEC[k][2*W+1 -: W];
            b = VEC[k][W+1 -: W];
            arr_x = a; arr_y = b;
            send_word(a, b, 1'b0);
            chk("R8 table serial", ser_out(), code_vec(VEC[k][1:0]));
            chk("R9 table array", arr_out(), code_vec(VEC[k][1:0]));
        end

        // R5 from equal: greater, less, equal
        step(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R5 eq->gt", ser_out(), 3'b100);
        // R6 later bits favour Y but relation sticks
        step(1'b0, 1'b1, 1'b0, 1'b1);
        chk("R6 gt sticky", ser_out(), 3'b100);
        // R4 idle with opposing bits
        step(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R4 idle hold", ser_out(), 3'b100);
        // R3 start+valid while greater applies pair from equal
        step(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R3 start+valid lt", ser_out(), 3'b001);
        step(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R6 lt sticky", ser_out(), 3'b001);
        // R2 start alone clears
        step(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R2 start clears", ser_out(), 3'b010);
        step(1'b0, 1'b1, 1'b1, 1'b1);
        chk("R5 eq stays eq", ser_out(), 3'b010);
        step(1'b0, 1'b1, 1'b0, 1'b1);
        chk("R5 eq->lt", ser_out(), 3'b001);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R3 start+valid eq", ser_out(), 3'b010);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 one-hot", ser_out(), 3'b010);

        // R8 with valid-low bubbles carrying misleading bits
        send_word(4'h9, 4'hA, 1'b1);
        chk("R8 bubbles lt", ser_out(), 3'b001);
        send_word(4'h3, 4'h2, 1'b1);
        chk("R8 bubbles gt", ser_out(), 3'b100);

        // R1 reset mid-word
        step(1'b1, 1'b1, 1'b1, 1'b0);
        rst_n = 1'b0;
        step(1'b0, 1'b1, 1'b0, 1'b1);
        chk("R1 reset mid word", ser_out(), 3'b010);
        rst_n = 1'b1;

        // exhaustive sweep: R8, R9, R10
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                arr_x = W'(a); arr_y = W'(b);
                send_word(W'(a), W'(b), 1'b0);
                chk("R8 sweep serial", ser_out(), ref_vec(W'(a), W'(b)));
                chk("R9 sweep array", arr_out(), ref_vec(W'(a), W'(b)));
                chk("R10 array vs serial", arr_out(), ser_out());
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule